// File: doc/BRIEF.md
# Serial Port FIFO Pair with Threshold Flags

This block holds the byte queues that sit between a serial shifter and the bus side of a serial port. It has two first-in first-out stores of 16 bytes each. The receive queue is filled by the line side and drained by software or DMA. The transmit queue is filled by software and drained by the line side. Each queue reports how many bytes it holds.

Each queue also drives a request flag against a programmable threshold. The receive "data ready" flag rises once enough bytes have collected. The transmit "space available" flag rises once few enough bytes remain queued.

A small configuration register holds the link mode (asynchronous or clocked synchronous) and a 2-bit trigger code for each direction. The receive trigger code is decoded differently in the two modes. Both flags are sticky: software clears them with a strobe, and a clear has no effect while the threshold condition still holds.

Top module: `serial_fifo_flags`

## Requirements
- R1: Each queue holds up to 16 bytes and returns them in arrival order. `*_rdata` shows the oldest byte while the queue is not empty. `*_level` reports 0 to 16 entries and updates on the clock edge that takes a push or pop.
- R2: With `cfg_sync_mode`=0 (asynchronous), receive trigger codes 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14 bytes.
- R3: With `cfg_sync_mode`=1 (clocked synchronous), receive trigger codes 0, 1, 2 and 3 give thresholds of 1, 2, 8 and 14 bytes.
- R4: `rx_ready_flag` is 1 from the same edge on which `rx_level` reaches or exceeds the receive threshold. The comparison uses the level and the configuration as updated on that edge.
- R5: Transmit trigger codes 0, 1, 2 and 3 give remaining-byte thresholds of 8, 4, 2 and 0. `tx_space_flag` is 1 from the same edge on which `tx_level` falls to or below that threshold.
- R6: Each flag stays at 1 until its clear strobe is applied. The clear drops the flag at the next edge only if that edge's updated level no longer meets the threshold. Otherwise the flag stays at 1.
- R7: A push to a full queue or a pop from an empty queue is ignored. It raises the matching `*_overrun` or `*_underrun` output for exactly one cycle after the edge.
- R8: A push and a pop on the same edge to a queue that is neither empty nor full leave the level unchanged. On a full queue only the pop is taken. On an empty queue only the push is taken.
- R9: A flush strobe empties its queue on the next edge and ignores a push or pop in the same cycle. After a flush `rx_ready_flag` is 0 and `tx_space_flag` is 1.
- R10: After reset both levels are 0, the mode is asynchronous, both trigger codes are 0, `rx_ready_flag` is 0 and `tx_space_flag` is 1. `cfg_wr` loads the mode and both codes on an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load configuration fields |
| cfg_sync_mode | input | 1 | 0 asynchronous, 1 clocked synchronous |
| cfg_rx_trig | input | 2 | Receive trigger code |
| cfg_tx_trig | input | 2 | Transmit trigger code |
| rx_push | input | 1 | Write a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_flush | input | 1 | Empty the receive queue |
| rx_flag_clr | input | 1 | Clear request for the data-ready flag |
| rx_level | output | 5 | Receive queue occupancy |
| rx_ready_flag | output | 1 | Receive threshold reached |
| rx_overrun | output | 1 | Push to full receive queue was dropped |
| rx_underrun | output | 1 | Pop from empty receive queue was dropped |
| tx_push | input | 1 | Queue a byte for sending |
| tx_wdata | input | 8 | Byte to send |
| tx_pop | input | 1 | Remove the oldest queued byte |
| tx_rdata | output | 8 | Oldest queued byte |
| tx_flush | input | 1 | Empty the transmit queue |
| tx_flag_clr | input | 1 | Clear request for the space-available flag |
| tx_level | output | 5 | Transmit queue occupancy |
| tx_space_flag | output | 1 | Transmit remaining-byte threshold reached |
| tx_overrun | output | 1 | Push to full transmit queue was dropped |
| tx_underrun | output | 1 | Pop from empty transmit queue was dropped |

## Verification
The assertions assume that every strobe is a known 0 or 1 at each edge. They also assume that thresholds change only through `cfg_wr`, so the clear-strobe property excludes cycles that load a new configuration. The stimulus drives every input with defined values away from the clock edge and holds each strobe for exactly one cycle. It also walks every trigger code in both modes, and for each code it fills and drains the queues across the threshold boundary.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  typedef enum logic {
    LINK_ASYNC   = 1'b0,
    LINK_CLOCKED = 1'b1
  } link_mode_e;

  // Receive threshold: the code-1 step depends on the link mode.
  function automatic int unsigned rx_threshold(logic [1:0] code, link_mode_e mode);
    unique case (code)
      2'd0:    return 1;
      2'd1:    return (mode == LINK_CLOCKED) ? 2 : 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // Transmit threshold in bytes still queued.
  function automatic int unsigned tx_threshold(logic [1:0] code);
    unique case (code)
      2'd0:    return 8;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  level_nxt,
  output logic              overrun,
  output logic              underrun
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_nxt, rd_ptr, rd_ptr_nxt;
  logic              ovr_nxt, und_nxt;
  logic              is_full, is_empty, push_ok, pop_ok;

  assign is_full  = (level == LVL_W'(DEPTH));
  assign is_empty = (level == '0);
  assign push_ok  = push && !is_full && !flush;
  assign pop_ok   = pop && !is_empty && !flush;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    level_nxt  = level;
    ovr_nxt    = 1'b0;
    und_nxt    = 1'b0;
    if (flush) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      level_nxt  = '0;
    end else begin
      ovr_nxt = push && is_full;
      und_nxt = pop && is_empty;
      if (push_ok) wr_ptr_nxt = bump(wr_ptr);
      if (pop_ok)  rd_ptr_nxt = bump(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   level_nxt = level + 1'b1;
        2'b01:   level_nxt = level - 1'b1;
        default: level_nxt = level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overrun  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      wr_ptr   <= wr_ptr_nxt;
      rd_ptr   <= rd_ptr_nxt;
      level    <= level_nxt;
      overrun  <= ovr_nxt;
      underrun <= und_nxt;
    end
  end

  // Storage array carries no reset.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

endmodule

// File: rtl/sfifo_flag.sv
module sfifo_flag #(
  parameter int LVL_W = 5,
  parameter bit IS_TX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             clr,
  input  logic [LVL_W-1:0] level_nxt,
  input  logic [LVL_W-1:0] thresh_nxt,
  output logic             flag
);

  localparam logic RST_VAL = IS_TX;

  logic cond, flag_nxt;

  generate
    if (IS_TX) begin : g_space
      assign cond     = (level_nxt <= thresh_nxt);
      assign flag_nxt = cond || (flag && !clr);
    end else begin : g_ready
      assign cond     = (level_nxt >= thresh_nxt);
      assign flag_nxt = !flush && (cond || (flag && !clr));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= RST_VAL;
    else        flag <= flag_nxt;
  end

endmodule

// File: rtl/serial_fifo_flags.sv
module serial_fifo_flags
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sync_mode,
  input  logic [1:0]        cfg_rx_trig,
  input  logic [1:0]        cfg_tx_trig,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              rx_flush,
  input  logic              rx_flag_clr,
  output logic [LVL_W-1:0]  rx_level,
  output logic              rx_ready_flag,
  output logic              rx_overrun,
  output logic              rx_underrun,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  input  logic              tx_flush,
  input  logic              tx_flag_clr,
  output logic [LVL_W-1:0]  tx_level,
  output logic              tx_space_flag,
  output logic              tx_overrun,
  output logic              tx_underrun
);

  link_mode_e mode_q, mode_nxt;
  logic [1:0] rx_trig_q, rx_trig_nxt, tx_trig_q, tx_trig_nxt;
  logic [LVL_W-1:0] rx_thr_nxt, tx_thr_nxt, rx_thr_cur, tx_thr_cur;
  logic [LVL_W-1:0] rx_level_nxt, tx_level_nxt;

  // Configuration next state with an explicit load enable.
  always_comb begin
    mode_nxt    = mode_q;
    rx_trig_nxt = rx_trig_q;
    tx_trig_nxt = tx_trig_q;
    if (cfg_wr) begin
      mode_nxt    = link_mode_e'(cfg_sync_mode);
      rx_trig_nxt = cfg_rx_trig;
      tx_trig_nxt = cfg_tx_trig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= LINK_ASYNC;
      rx_trig_q <= 2'b00;
      tx_trig_q <= 2'b00;
    end else begin
      mode_q    <= mode_nxt;
      rx_trig_q <= rx_trig_nxt;
      tx_trig_q <= tx_trig_nxt;
    end
  end

  // Flags compare against the configuration in force after this edge.
  assign rx_thr_nxt = LVL_W'(rx_threshold(rx_trig_nxt, mode_nxt));
  assign tx_thr_nxt = LVL_W'(tx_threshold(tx_trig_nxt));
  assign rx_thr_cur = LVL_W'(rx_threshold(rx_trig_q, mode_q));
  assign tx_thr_cur = LVL_W'(tx_threshold(tx_trig_q));

  sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_store (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
    .level(rx_level), .level_nxt(rx_level_nxt),
    .overrun(rx_overrun), .underrun(rx_underrun)
  );

  sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_store (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
    .level(tx_level), .level_nxt(tx_level_nxt),
    .overrun(tx_overrun), .underrun(tx_underrun)
  );

  sfifo_flag #(.LVL_W(LVL_W), .IS_TX(1'b0)) u_rx_flag (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .clr(rx_flag_clr),
    .level_nxt(rx_level_nxt), .thresh_nxt(rx_thr_nxt), .flag(rx_ready_flag)
  );

  sfifo_flag #(.LVL_W(LVL_W), .IS_TX(1'b1)) u_tx_flag (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .clr(tx_flag_clr),
    .level_nxt(tx_level_nxt), .thresh_nxt(tx_thr_nxt), .flag(tx_space_flag)
  );

endmodule

// File: rtl/sfifo_flags_chk.sv
module sfifo_flags_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             rx_flush,
  input logic             rx_flag_clr,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_ready_flag,
  input logic             rx_overrun,
  input logic [LVL_W-1:0] rx_thr,
  input logic             tx_push,
  input logic             tx_pop,
  input logic             tx_flush,
  input logic [LVL_W-1:0] tx_level,
  input logic             tx_space_flag,
  input logic             tx_underrun,
  input logic [LVL_W-1:0] tx_thr
);

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= LVL_W'(DEPTH)) && (tx_level <= LVL_W'(DEPTH)));

  // R4
  rx_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= rx_thr) |-> rx_ready_flag);

  // R5
  tx_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= tx_thr) |-> tx_space_flag);

  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag_clr && !rx_push && !rx_flush && !cfg_wr && (rx_level < rx_thr))
    |=> !rx_ready_flag);

  // R7
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_flush && (rx_level == LVL_W'(DEPTH))) |=> rx_overrun);

  // R7
  tx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && !tx_flush && (tx_level == '0)) |=> tx_underrun);

  // R8
  rx_pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_pop && !rx_flush && (rx_level != '0) &&
     (rx_level != LVL_W'(DEPTH))) |=> $stable(rx_level));

  // R9
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> ((rx_level == '0) && !rx_ready_flag));

  // R9
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> ((tx_level == '0) && tx_space_flag));

endmodule

bind serial_fifo_flags sfifo_flags_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_flush(rx_flush),
  .rx_flag_clr(rx_flag_clr), .rx_level(rx_level),
  .rx_ready_flag(rx_ready_flag), .rx_overrun(rx_overrun), .rx_thr(rx_thr_cur),
  .tx_push(tx_push), .tx_pop(tx_pop), .tx_flush(tx_flush),
  .tx_level(tx_level), .tx_space_flag(tx_space_flag),
  .tx_underrun(tx_underrun), .tx_thr(tx_thr_cur)
);

// File: tb/sim_serial_fifo_flags.sv
`timescale 1ns/1ps
module sim_serial_fifo_flags;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sync_mode = 0;
  logic [1:0] cfg_rx_trig = 0, cfg_tx_trig = 0;
  logic rx_push = 0, rx_pop = 0, rx_flush = 0, rx_flag_clr = 0;
  logic tx_push = 0, tx_pop = 0, tx_flush = 0, tx_flag_clr = 0;
  logic [7:0] rx_wdata = 0, tx_wdata = 0;
  logic [7:0] rx_rdata, tx_rdata;
  logic [4:0] rx_level, tx_level;
  logic rx_ready_flag, tx_space_flag, rx_overrun, rx_underrun, tx_overrun, tx_underrun;

  always #2 clk = ~clk;

  serial_fifo_flags u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sync_mode(cfg_sync_mode),
    .cfg_rx_trig(cfg_rx_trig), .cfg_tx_trig(cfg_tx_trig),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_flush(rx_flush), .rx_flag_clr(rx_flag_clr), .rx_level(rx_level),
    .rx_ready_flag(rx_ready_flag), .rx_overrun(rx_overrun), .rx_underrun(rx_underrun),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_flush(tx_flush), .tx_flag_clr(tx_flag_clr), .tx_level(tx_level),
    .tx_space_flag(tx_space_flag), .tx_overrun(tx_overrun), .tx_underrun(tx_underrun)
  );

  int checks = 0, errors = 0;
  string tag = "R10";

  // Behavioural reference model
  logic [7:0] rq[$], tq[$];
  bit m_sync, m_rf, m_tf, m_rovr, m_rund, m_tovr, m_tund;
  int m_rt, m_tt;

  function automatic int rthr(int c, bit s);
    case (c)
      0: return 1;
      1: return s ? 2 : 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int tthr(int c);
    case (c)
      0: return 8;
      1: return 4;
      2: return 2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq.delete(); tq.delete();
      m_sync = 0; m_rt = 0; m_tt = 0; m_rf = 0; m_tf = 1;
      m_rovr = 0; m_rund = 0; m_tovr = 0; m_tund = 0;
    end else begin
      if (cfg_wr) begin
        m_sync = cfg_sync_mode; m_rt = cfg_rx_trig; m_tt = cfg_tx_trig;
      end
      m_rovr = 0; m_rund = 0; m_tovr = 0; m_tund = 0;
      if (rx_flush) begin
        rq.delete(); m_rf = 0;
      end else begin
        bit pu, po;
        pu = rx_push && rq.size() < 16;
        po = rx_pop && rq.size() > 0;
        m_rovr = rx_push && rq.size() == 16;
        m_rund = rx_pop && rq.size() == 0;
        if (po) void'(rq.pop_front());
        if (pu) rq.push_back(rx_wdata);
        m_rf = (rq.size() >= rthr(m_rt, m_sync)) || (m_rf && !rx_flag_clr);
      end
      if (tx_flush) begin
        tq.delete();
      end else begin
        bit pu, po;
        pu = tx_push && tq.size() < 16;
        po = tx_pop && tq.size() > 0;
        m_tovr = tx_push && tq.size() == 16;
        m_tund = tx_pop && tq.size() == 0;
        if (po) void'(tq.pop_front());
        if (pu) tq.push_back(tx_wdata);
      end
      m_tf = (tq.size() <= tthr(m_tt)) || (m_tf && !tx_flag_clr);
    end
  end

  task automatic ck(int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    ck(rx_level, rq.size(), "rx_level (R1)");
    ck(tx_level, tq.size(), "tx_level (R1)");
    ck(rx_ready_flag, m_rf, "rx_ready_flag (R4)");
    ck(tx_space_flag, m_tf, "tx_space_flag (R5)");
    ck(rx_overrun, m_rovr, "rx_overrun (R7)");
    ck(rx_underrun, m_rund, "rx_underrun (R7)");
    ck(tx_overrun, m_tovr, "tx_overrun (R7)");
    ck(tx_underrun, m_tund, "tx_underrun (R7)");
    if (rq.size() > 0) ck(rx_rdata, rq[0], "rx_rdata (R1)");
    if (tq.size() > 0) ck(tx_rdata, tq[0], "tx_rdata (R1)");
  endtask

  // Apply the inputs set by the caller for one cycle, then check.
  task automatic cyc();
    @(negedge clk);
    compare_all();
    cfg_wr = 0; rx_push = 0; rx_pop = 0; rx_flush = 0; rx_flag_clr = 0;
    tx_push = 0; tx_pop = 0; tx_flush = 0; tx_flag_clr = 0;
  endtask

  task automatic cfg(bit s, int rt, int tt);
    cfg_wr = 1; cfg_sync_mode = s; cfg_rx_trig = 2'(rt); cfg_tx_trig = 2'(tt);
    cyc();
  endtask

  task automatic rx_fill_drain(bit s);
    for (int c = 0; c < 4; c++) begin
      cfg(s, c, 0);
      rx_flush = 1; cyc();
      for (int k = 0; k < 16; k++) begin
        rx_push = 1; rx_wdata = 8'($urandom); cyc();
        ck(rx_ready_flag, (k + 1) >= rthr(c, s), "rx threshold boundary");
      end
      for (int k = 0; k < 16; k++) begin
        rx_pop = 1; rx_flag_clr = 1; cyc();
      end
    end
  endtask

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired in phase %s", tag);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state and default trigger codes
    tag = "R10";
    ck(rx_level, 0, "rx_level after reset");
    ck(tx_level, 0, "tx_level after reset");
    ck(rx_ready_flag, 0, "rx flag after reset");
    ck(tx_space_flag, 1, "tx flag after reset");
    rx_push = 1; rx_wdata = 8'h5a; cyc();
    ck(rx_ready_flag, 1, "rx default threshold 1");
    for (int k = 0; k < 9; k++) begin tx_push = 1; tx_wdata = 8'(k); cyc(); end
    ck(tx_space_flag, 1, "tx flag sticky at 9 bytes");
    tx_flag_clr = 1; cyc();
    ck(tx_space_flag, 0, "tx flag cleared above default threshold 8");
    tx_pop = 1; cyc();
    ck(tx_space_flag, 1, "tx flag at default threshold 8");

    tag = "R2"; rx_fill_drain(1'b0);
    tag = "R3"; rx_fill_drain(1'b1);

    tag = "R5";
    for (int c = 0; c < 4; c++) begin
      cfg(0, 0, c);
      tx_flush = 1; cyc();
      for (int k = 0; k < 16; k++) begin tx_push = 1; tx_wdata = 8'($urandom); tx_flag_clr = 1; cyc(); end
      for (int k = 0; k < 16; k++) begin
        tx_pop = 1; cyc();
        ck(tx_space_flag, (15 - k) <= tthr(c), "tx threshold boundary");
      end
    end

    tag = "R6";
    cfg(0, 2, 0);
    rx_flush = 1; cyc();
    for (int k = 0; k < 10; k++) begin rx_push = 1; rx_wdata = 8'(k); cyc(); end
    rx_flag_clr = 1; cyc();
    ck(rx_ready_flag, 1, "clear ignored while condition holds");
    rx_pop = 1; cyc(); rx_pop = 1; cyc(); rx_pop = 1; cyc();
    ck(rx_ready_flag, 1, "flag sticky below threshold");
    rx_flag_clr = 1; cyc();
    ck(rx_ready_flag, 0, "clear below threshold");

    tag = "R7";
    rx_flush = 1; tx_flush = 1; cyc();
    for (int k = 0; k < 18; k++) begin rx_push = 1; rx_wdata = 8'(100 + k); cyc(); end
    ck(rx_overrun, 1, "overrun after push to full");
    tx_pop = 1; cyc();
    ck(tx_underrun, 1, "underrun after pop from empty");
    ck(tx_level, 0, "tx level unchanged by underrun");

    tag = "R8";
    rx_push = 1; rx_pop = 1; rx_wdata = 8'hee; cyc();
    ck(rx_level, 15, "push+pop on full takes only pop");
    rx_push = 1; rx_pop = 1; rx_wdata = 8'hdd; cyc();
    ck(rx_level, 15, "push+pop mid level unchanged");
    tx_push = 1; tx_pop = 1; tx_wdata = 8'h33; cyc();
    ck(tx_level, 1, "push+pop on empty takes only push");

    tag = "R9";
    rx_flush = 1; rx_push = 1; tx_flush = 1; tx_pop = 1; cyc();
    ck(rx_level, 0, "rx flushed");
    ck(rx_ready_flag, 0, "rx flag after flush");
    ck(tx_space_flag, 1, "tx flag after flush");

    tag = "R1";
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 64) == 0) begin
        cfg_wr = 1; cfg_sync_mode = 1'($urandom); cfg_rx_trig = 2'($urandom); cfg_tx_trig = 2'($urandom);
      end
      rx_push = ($urandom % 3) != 0; rx_pop = ($urandom % 3) == 0; rx_wdata = 8'($urandom);
      tx_push = ($urandom % 3) == 0; tx_pop = ($urandom % 3) != 0; tx_wdata = 8'($urandom);
      rx_flag_clr = ($urandom % 4) == 0; tx_flag_clr = ($urandom % 4) == 0;
      rx_flush = ($urandom % 200) == 0; tx_flush = ($urandom % 200) == 0;
      cyc();
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule